// File: doc/BRIEF.md
# Prefixed Multiply-Divide Extension Unit

This unit sits beside the accumulator of a small 8-bit processor and executes the instructions of the extended group. That group is reached through the prefix byte 86h. The core fetches the prefix and the second opcode byte, then presents the second byte on `ext_op` with `issue` high for one cycle. With it come the current accumulator, the byte read from memory at the address held in the X register, and the immediate byte of the instruction. The unit owns an extra 8-bit high-byte register, which pairs with the accumulator to form a 16-bit quantity for multiply and divide.

Every supported operation finishes in a single clock. The new accumulator value appears on `acc_out`, with `res_valid` high, on the clock edge that captures the issue. The high-byte register updates on that same edge and can always be read on `hi_out`. If the second byte has no meaning to this unit, the operation changes nothing and `unsup` is raised for that result. Register-file operations of the same group, instruction fetch and bus access belong to the core.

Top module: `mdx_unit`

## Requirements
- R1: After reset the high-byte register reads 00h, and `res_valid` and `unsup` are low.
- R2: Second byte 7Bh returns the accumulator with its two 4-bit halves exchanged. The high-byte register is unchanged.
- R3: Second byte A0h sets the high-byte register to 00h. A1h loads it from the accumulator. 90h returns its value as the new accumulator. For A0h and A1h the accumulator is returned unchanged.
- R4: Second bytes F4h and FCh multiply the accumulator by the operand as unsigned values. The product's low byte becomes the accumulator and its high byte becomes the high-byte register. In the Fxh codes, bit 3 of the second byte selects the operand: 0 takes `mem_opnd`, 1 takes `imm_opnd`.
- R5: Second bytes F5h (memory) and FDh (immediate) divide {high-byte, accumulator} by the operand as unsigned values. The quotient's low byte becomes the accumulator and its high byte becomes the high-byte register.
- R6: Second bytes F3h (memory) and FBh (immediate) return the remainder of {high-byte, accumulator} divided by the operand as the new accumulator. The high-byte register keeps its value.
- R7: A zero divisor raises no trap. A divide sets both registers to FFh. A modulo returns the accumulator unchanged and keeps the high-byte register.
- R8: The result of an operation issued in one cycle is on `acc_out` and `hi_out`, with `res_valid` high, right after the next rising clock edge. `res_valid` is low after any edge where `issue` was low.
- R9: Any other second byte raises `unsup` with `res_valid`, returns the accumulator unchanged and leaves the high-byte register as it was.
- R10: While `issue` is low, the high-byte register holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | One extended operation is presented this cycle |
| ext_op | input | 8 | Second opcode byte following the prefix |
| acc_in | input | 8 | Current accumulator value |
| mem_opnd | input | 8 | Byte read from memory at the X-register address |
| imm_opnd | input | 8 | Immediate byte of the instruction |
| res_valid | output | 1 | `acc_out` carries the result of the last issued operation |
| acc_out | output | 8 | New accumulator value |
| hi_out | output | 8 | High-byte register |
| unsup | output | 1 | The last issued second byte was not recognised |

## Verification
A corrupted high-byte register shows on `hi_out` right after the edge that wrote it. It spreads into the next divide or modulo, because those read the register as the upper dividend byte. The bench therefore keeps its own model of the register across whole chains of loads, multiplies and divides, so a stale or wrongly updated value is reported at the next result rather than only at the faulty operation. A mis-decoded operand select or opcode shows as a wrong `acc_out` one edge after issue. The sweeps cover both operand sources, zero divisors and quotients wider than 8 bits.

// File: rtl/mdx_pkg.sv
package mdx_pkg;

    typedef enum logic [2:0] {
        XOP_NONE,
        XOP_SWAP,
        XOP_HCLR,
        XOP_HLOAD,
        XOP_HGET,
        XOP_MUL,
        XOP_DIV,
        XOP_MOD
    } xop_e;

    localparam logic [7:0] OPC_SWAP  = 8'h7B;
    localparam logic [7:0] OPC_HCLR  = 8'hA0;
    localparam logic [7:0] OPC_HLOAD = 8'hA1;
    localparam logic [7:0] OPC_HGET  = 8'h90;
    localparam logic [7:0] OPC_MULM  = 8'hF4;
    localparam logic [7:0] OPC_MULI  = 8'hFC;
    localparam logic [7:0] OPC_DIVM  = 8'hF5;
    localparam logic [7:0] OPC_DIVI  = 8'hFD;
    localparam logic [7:0] OPC_MODM  = 8'hF3;
    localparam logic [7:0] OPC_MODI  = 8'hFB;

endpackage

// File: rtl/mdx_decode.sv
module mdx_decode
    import mdx_pkg::*;
(
    input  logic [7:0] ext_op,
    output xop_e       kind,
    output logic       use_imm
);
    always_comb begin
        use_imm = 1'b0;
        unique case (ext_op)
            OPC_SWAP:           kind = XOP_SWAP;
            OPC_HCLR:           kind = XOP_HCLR;
            OPC_HLOAD:          kind = XOP_HLOAD;
            OPC_HGET:           kind = XOP_HGET;
            OPC_MULM, OPC_MULI: kind = XOP_MUL;
            OPC_DIVM, OPC_DIVI: kind = XOP_DIV;
            OPC_MODM, OPC_MODI: kind = XOP_MOD;
            default:            kind = XOP_NONE;
        endcase
        // bit 3 picks the immediate operand within the Fxh group
        if (kind == XOP_MUL || kind == XOP_DIV || kind == XOP_MOD)
            use_imm = ext_op[3];
    end
endmodule

// File: rtl/mdx_mult.sv
module mdx_mult #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int PW = 2 * W;

    logic [PW-1:0] part [W];

    for (genvar i = 0; i < W; i++) begin : g_part
        assign part[i] = b[i] ? ({{W{1'b0}}, a} << i) : '0;
    end

    always_comb begin
        p = '0;
        for (int i = 0; i < W; i++) p = p + part[i];
    end
endmodule

// File: rtl/mdx_div.sv
module mdx_div #(
    parameter int W = 8
) (
    input  logic [2*W-1:0] num,
    input  logic [W-1:0]   den,
    output logic [2*W-1:0] quo,
    output logic [W-1:0]   rem
);
    localparam int NW = 2 * W;

    logic [W:0] r;

    // restoring long division, one quotient bit per unrolled stage
    always_comb begin
        r   = '0;
        quo = '0;
        for (int i = NW - 1; i >= 0; i--) begin
            r = {r[W-1:0], num[i]};
            if (r >= {1'b0, den}) begin
                r      = r - {1'b0, den};
                quo[i] = 1'b1;
            end
        end
        rem = r[W-1:0];
    end
endmodule

// File: rtl/mdx_unit.sv
module mdx_unit
    import mdx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue,
    input  logic [7:0]   ext_op,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] mem_opnd,
    input  logic [W-1:0] imm_opnd,
    output logic         res_valid,
    output logic [W-1:0] acc_out,
    output logic [W-1:0] hi_out,
    output logic         unsup
);
    localparam int HW = W / 2;

    typedef struct packed {
        logic         vld;
        logic         bad;
        logic [W-1:0] acc;
        logic [W-1:0] hi;
    } unit_state_t;

    unit_state_t st_d, st_q;
    xop_e        kind;
    logic        use_imm;
    logic [W-1:0]   opnd;
    logic [2*W-1:0] prod, quo;
    logic [W-1:0]   rem;
    logic           den_zero;

    mdx_decode u_dec (
        .ext_op (ext_op),
        .kind   (kind),
        .use_imm(use_imm)
    );

    assign opnd     = use_imm ? imm_opnd : mem_opnd;
    assign den_zero = (opnd == '0);

    mdx_mult #(.W(W)) u_mul (.a(acc_in), .b(opnd), .p(prod));

    mdx_div #(.W(W)) u_div (
        .num({st_q.hi, acc_in}),
        .den(opnd),
        .quo(quo),
        .rem(rem)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = issue;
        st_d.bad = 1'b0;
        if (issue) begin
            st_d.acc = acc_in;
            unique case (kind)
                XOP_SWAP:  st_d.acc = {acc_in[HW-1:0], acc_in[W-1:HW]};
                XOP_HCLR:  st_d.hi  = '0;
                XOP_HLOAD: st_d.hi  = acc_in;
                XOP_HGET:  st_d.acc = st_q.hi;
                XOP_MUL:   {st_d.hi, st_d.acc} = prod;
                XOP_DIV:   {st_d.hi, st_d.acc} = den_zero ? '1 : quo;
                XOP_MOD:   st_d.acc = den_zero ? acc_in : rem;
                default:   st_d.bad = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.vld;
    assign unsup     = st_q.bad;
    assign acc_out   = st_q.acc;
    assign hi_out    = st_q.hi;

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> res_valid);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> ($stable(hi_out) && !res_valid && !unsup));

    p_mod_keeps_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (ext_op == OPC_MODM || ext_op == OPC_MODI)) |=> $stable(hi_out));

    p_clear_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && ext_op == OPC_HCLR) |=> (hi_out == '0));

    p_swap_halves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && ext_op == OPC_SWAP) |=>
            (acc_out == {$past(acc_in[HW-1:0]), $past(acc_in[W-1:HW])}));

    p_unsup_noeffect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && unsup) |-> ($stable(hi_out) && acc_out == $past(acc_in)));

    p_divzero_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && ext_op == OPC_DIVM && mem_opnd == '0) |=>
            (acc_out == '1 && hi_out == '1));
endmodule

// File: tb/mdx_unit_test.sv
`timescale 1ns/1ps
module mdx_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue = 1'b0;
    logic [7:0] ext_op = 8'h00;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] mem_opnd = 8'h00;
    logic [7:0] imm_opnd = 8'h00;
    logic       res_valid, unsup;
    logic [7:0] acc_out, hi_out;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] hi_m = 8'h00;

    always #4 clk = ~clk;

    mdx_unit uut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .ext_op(ext_op),
        .acc_in(acc_in), .mem_opnd(mem_opnd), .imm_opnd(imm_opnd),
        .res_valid(res_valid), .acc_out(acc_out), .hi_out(hi_out), .unsup(unsup)
    );

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s op=%h acc=%h mem=%h imm=%h actual={v,u,acc,hi}=%h expected=%h",
                     req, ext_op, acc_in, mem_opnd, imm_opnd, act, exp);
        end
    endtask

    // issue one op, compute the expected result arithmetically, check after the edge
    task automatic run(input string req, input logic [7:0] op, input logic [7:0] a,
                       input logic [7:0] m, input logic [7:0] im);
        logic [7:0]  o, ea, eh;
        logic        eu;
        logic [15:0] n, r;
        @(negedge clk);
        issue = 1'b1; ext_op = op; acc_in = a; mem_opnd = m; imm_opnd = im;
        o  = op[3] ? im : m;
        n  = {hi_m, a};
        ea = a; eh = hi_m; eu = 1'b0;
        case (op)
            8'h7B: ea = {a[3:0], a[7:4]};
            8'hA0: eh = 8'h00;
            8'hA1: eh = a;
            8'h90: ea = hi_m;
            8'hF4, 8'hFC: begin r = a * o; {eh, ea} = r; end
            8'hF5, 8'hFD: begin r = (o == 0) ? 16'hFFFF : n / {8'h00, o}; {eh, ea} = r; end
            8'hF3, 8'hFB: begin r = (o == 0) ? {8'h00, a} : n % {8'h00, o}; ea = r[7:0]; end
            default: eu = 1'b1;
        endcase
        @(posedge clk); #1;
        chk(req, {res_valid, unsup, acc_out, hi_out}, {1'b1, eu, ea, eh});
        hi_m = eh;
        issue = 1'b0;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", {res_valid, unsup, acc_out, hi_out}, {1'b0, 1'b0, acc_out, 8'h00});
        @(negedge clk); rst_n = 1'b1;

        // R2, R3: swap and high-byte moves, full sweep of accumulator
        for (int a = 0; a < 256; a++) begin
            run("R2", 8'h7B, a[7:0], 8'h00, 8'h00);
            run("R3", 8'hA1, a[7:0], 8'h00, 8'h00);
            run("R3", 8'h90, ~a[7:0], 8'h00, 8'h00);
        end
        run("R3", 8'hA0, 8'h55, 8'h00, 8'h00);
        run("R3", 8'h90, 8'h77, 8'h00, 8'h00);

        // R4: multiply, both operand sources, other source driven with a decoy
        for (int a = 0; a < 256; a += 3)
            for (int b = 0; b < 256; b += 5) begin
                run("R4", 8'hF4, a[7:0], b[7:0], ~b[7:0]);
                run("R4", 8'hFC, a[7:0], ~b[7:0], b[7:0]);
            end
        run("R4", 8'hF4, 8'hFF, 8'hFF, 8'h00);

        // R5, R6, R7: divide and modulo over dividends and divisors incl. zero
        for (int h = 0; h < 256; h += 17)
            for (int l = 0; l < 256; l += 29)
                for (int d = 0; d < 256; d += 13) begin
                    run("R3", 8'hA1, h[7:0], 8'h00, 8'h00);
                    run((d == 0) ? "R7" : "R6", 8'hF3, l[7:0], d[7:0], 8'hAA);
                    run((d == 0) ? "R7" : "R5", 8'hFD, l[7:0], 8'h5A, d[7:0]);
                    run("R3", 8'hA1, h[7:0], 8'h00, 8'h00);
                    run((d == 0) ? "R7" : "R5", 8'hF5, l[7:0], d[7:0], 8'h33);
                    run((d == 0) ? "R7" : "R6", 8'hFB, l[7:0], 8'hC3, d[7:0]);
                end
        run("R3", 8'hA1, 8'hFF, 8'h00, 8'h00);
        run("R5", 8'hF5, 8'hFF, 8'h01, 8'h00);

        // R9: unsupported second bytes leave everything alone
        run("R3", 8'hA1, 8'h3C, 8'h00, 8'h00);
        for (int op = 0; op < 256; op++)
            run("R9", op[7:0], op[7:0] ^ 8'h96, 8'h07, 8'h09);

        // R10, R8: idle cycles with busy inputs hold the high byte, no result
        run("R3", 8'hA1, 8'hC9, 8'h00, 8'h00);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            issue = 1'b0; ext_op = 8'hA0; acc_in = k[7:0]; mem_opnd = 8'h00;
            @(posedge clk); #1;
            chk("R10", {res_valid, unsup, 8'h00, hi_out}, {1'b0, 1'b0, 8'h00, 8'hC9});
        end
        run("R8", 8'h90, 8'h00, 8'h00, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule